// File: doc/BRIEF.md
# Masked Bit-Manipulation Logic Unit

This unit takes one operand and builds two intermediate words from it. The first word is either the operand or its bitwise inverse. The second word is the result of one of four arithmetic-and-invert steps. A selectable boolean operation then merges the two words. The merged value is limited to a window given by a mask word. Outside that window, output bits are either cleared or copied from the operand. With the right mode, the same datapath yields common idioms such as isolating the lowest set bit, clearing a run of trailing ones, or building a mask that reaches up to and includes the first set bit.

A five-bit mode word drives the whole datapath. A separate flag tells the unit that no mask source was named; in that case the window covers the full width. The computation is purely combinational. The result is captured in one output register, so the answer to an input set appears one clock after those inputs are sampled.

Top module: `bmx_unit`

## Requirements
- R1: While `rst_n` is low, `result` is zero; after reset, `result` shows the value computed from the inputs sampled at the previous rising clock edge.
- R2: When `mask_src_none` is 1, the window is all ones and `mask_src` has no effect; otherwise the window is `mask_src`.
- R3: `mode[4]` = 0 makes the first word the bitwise inverse of `opnd`; `mode[4]` = 1 makes it `opnd` unchanged.
- R4: `mode[1:0]` picks the second word: 0 gives inverse of `opnd` plus one, 1 gives `opnd` minus one, 2 gives `opnd` plus one, 3 gives the inverse of (`opnd` plus one).
- R5: `mode[3:2]` picks the merge: 0 is OR, 1 is AND, 2 is XOR, 3 is a constant all-zero word.
- R6: With `keep_outside` = 0, every `result` bit where the window is 0 reads 0, and bits inside the window carry the merged value.
- R7: With `keep_outside` = 1, every `result` bit where the window is 0 equals the matching `opnd` bit.
- R8: Every increment and decrement wraps modulo 2^XLEN (all-ones plus one is zero, zero minus one is all-ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opnd | input | XLEN | Operand that feeds both intermediate words and the restore path |
| mask_src | input | XLEN | Window value, used when `mask_src_none` is 0 |
| mask_src_none | input | 1 | 1 forces an all-ones window |
| mode | input | 5 | [4] first-word select, [3:2] merge select, [1:0] second-word select |
| keep_outside | input | 1 | 1 copies `opnd` into bits outside the window |
| result | output | XLEN | Registered result |

## Verification
The only state is the output register, so any internal fault appears at `result` on the clock edge right after the offending inputs are sampled. A wrong pick of the second word or the merge gives a different value for the idioms, since those results depend on where the operand's lowest set bit lies. A fault in the window or restore path shows up as stray ones, or missing operand bits, outside the window. The wrap corners use all-ones and zero operands, because that is where a truncation or carry mistake would change the output.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    typedef enum logic [1:0] {
        SEC_NEG  = 2'd0,
        SEC_DEC  = 2'd1,
        SEC_INC  = 2'd2,
        SEC_NINC = 2'd3
    } second_sel_e;

    typedef enum logic [1:0] {
        CMB_OR   = 2'd0,
        CMB_AND  = 2'd1,
        CMB_XOR  = 2'd2,
        CMB_ZERO = 2'd3
    } comb_sel_e;

    localparam int unsigned MODE_W      = 5;
    localparam int unsigned MODE_PASS   = 4;
    localparam int unsigned MODE_CMB_LO = 2;

endpackage

// File: rtl/bmx_pre.sv
module bmx_pre
    import bmx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] opnd,
    input  logic            pass_opnd,
    input  second_sel_e     sec_sel,
    output logic [XLEN-1:0] first_w,
    output logic [XLEN-1:0] second_w
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] inc_w;
    logic [XLEN-1:0] dec_w;
    logic [XLEN-1:0] neg_w;

    always_comb begin
        inc_w = opnd + ONE;
        dec_w = opnd - ONE;
        neg_w = (~opnd) + ONE;
    end

    always_comb begin
        first_w = pass_opnd ? opnd : ~opnd;
    end

    always_comb begin
        unique case (sec_sel)
            SEC_NEG:  second_w = neg_w;
            SEC_DEC:  second_w = dec_w;
            SEC_INC:  second_w = inc_w;
            SEC_NINC: second_w = ~inc_w;
            default:  second_w = '0;
        endcase
    end

endmodule

// File: rtl/bmx_combine.sv
module bmx_combine
    import bmx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] x_w,
    input  logic [XLEN-1:0] y_w,
    input  comb_sel_e       op,
    output logic [XLEN-1:0] merged
);
    logic sel_or;
    logic sel_and;
    logic sel_xor;

    assign sel_or  = (op == CMB_OR);
    assign sel_and = (op == CMB_AND);
    assign sel_xor = (op == CMB_XOR);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign merged[i] = (sel_or  & (x_w[i] | y_w[i]))
                         | (sel_and & (x_w[i] & y_w[i]))
                         | (sel_xor & (x_w[i] ^ y_w[i]));
    end

endmodule

// File: rtl/bmx_window.sv
module bmx_window #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] merged,
    input  logic [XLEN-1:0] opnd,
    input  logic [XLEN-1:0] mask_src,
    input  logic            mask_src_none,
    input  logic            keep_outside,
    output logic [XLEN-1:0] windowed
);
    logic [XLEN-1:0] win;
    logic [XLEN-1:0] outside;

    always_comb begin
        win      = mask_src_none ? {XLEN{1'b1}} : mask_src;
        outside  = keep_outside ? (opnd & ~win) : '0;
        windowed = (merged & win) | outside;
    end

endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XLEN-1:0]         opnd,
    input  logic [XLEN-1:0]         mask_src,
    input  logic                    mask_src_none,
    input  logic [MODE_W-1:0]       mode,
    input  logic                    keep_outside,
    output logic [XLEN-1:0]         result
);
    typedef struct packed {
        logic [XLEN-1:0] res;
    } bmx_state_t;

    bmx_state_t      state_d;
    bmx_state_t      state_q;

    logic [XLEN-1:0] first_w;
    logic [XLEN-1:0] second_w;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] windowed;
    second_sel_e     sec_sel;
    comb_sel_e       cmb_sel;

    assign sec_sel = second_sel_e'(mode[1:0]);
    assign cmb_sel = comb_sel_e'(mode[MODE_CMB_LO+1:MODE_CMB_LO]);

    bmx_pre #(.XLEN(XLEN)) u_pre (
        .opnd      (opnd),
        .pass_opnd (mode[MODE_PASS]),
        .sec_sel   (sec_sel),
        .first_w   (first_w),
        .second_w  (second_w)
    );

    bmx_combine #(.XLEN(XLEN)) u_combine (
        .x_w    (first_w),
        .y_w    (second_w),
        .op     (cmb_sel),
        .merged (merged)
    );

    bmx_window #(.XLEN(XLEN)) u_window (
        .merged        (merged),
        .opnd          (opnd),
        .mask_src      (mask_src),
        .mask_src_none (mask_src_none),
        .keep_outside  (keep_outside),
        .windowed      (windowed)
    );

    always_comb begin
        state_d     = state_q;
        state_d.res = windowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;

endmodule

// File: rtl/bmx_unit_chk.sv
module bmx_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] opnd,
    input logic [XLEN-1:0] mask_src,
    input logic            mask_src_none,
    input logic [4:0]      mode,
    input logic            keep_outside,
    input logic [XLEN-1:0] result
);
    localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> result == '0); // R1

    AST_OUTSIDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(keep_outside))
        |-> (result & ~($past(mask_src_none) ? ONES : $past(mask_src))) == '0); // R6

    AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(keep_outside))
        |-> (result & ~($past(mask_src_none) ? ONES : $past(mask_src)))
            == ($past(opnd) & ~($past(mask_src_none) ? ONES : $past(mask_src)))); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode[3:2]) == 2'b11) && !$past(keep_outside))
        |-> result == '0); // R5

    AST_FULL_WINDOW_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_src_none) && ($past(mode) == 5'b10100))
        |-> result == ($past(opnd) & ((~$past(opnd)) + ONE))); // R2

endmodule

bind bmx_unit bmx_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bmx_unit_bench.sv
module bmx_unit_bench;
    localparam int unsigned XLEN = 64;
    localparam int unsigned NVEC = 13;
    localparam int unsigned WDOG = 5000;

    typedef struct packed {
        logic [15:0]     tag;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] m;
        logic            mz;
        logic [4:0]      md;
        logic            keep;
        logic [XLEN-1:0] exp;
    } vec_t;

    // Mode encoding: [4] first word = opnd (1) or its inverse (0);
    // [3:2] merge 0 OR 1 AND 2 XOR 3 zero; [1:0] second word 0 -x 1 x-1 2 x+1 3 ~(x+1).
    localparam vec_t VECS [NVEC] = '{
        '{"R5", 64'hB8, 64'h0, 1'b1, 5'b10100, 1'b0, 64'h08},
        '{"R4", 64'h57, 64'h0, 1'b1, 5'b10110, 1'b0, 64'h50},
        '{"R4", 64'hB8, 64'h0, 1'b1, 5'b11001, 1'b0, 64'h0F},
        '{"R3", 64'hB8, 64'h0, 1'b1, 5'b00011, 1'b0, 64'hFFFF_FFFF_FFFF_FF47},
        '{"R5", 64'hB8, 64'h0, 1'b1, 5'b11100, 1'b0, 64'h0},
        '{"R7", 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_FFFF_0000, 1'b0, 5'b11100, 1'b1,
                64'h1234_5678_0000_DEF0},
        '{"R6", 64'hB8, 64'hF0, 1'b0, 5'b10100, 1'b0, 64'h0},
        '{"R7", 64'hB8, 64'hF0, 1'b0, 5'b10100, 1'b1, 64'h08},
        '{"R2", 64'hB8, 64'h0, 1'b1, 5'b10100, 1'b0, 64'h08},
        '{"R8", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 5'b00010, 1'b0, 64'h0},
        '{"R8", 64'h0, 64'h0, 1'b1, 5'b00101, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{"R3", 64'hB8, 64'h0, 1'b1, 5'b01000, 1'b0, 64'h0F},
        '{"R2", 64'hB8, 64'h0, 1'b1, 5'b10100, 1'b1, 64'h08}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] opnd = '0;
    logic [XLEN-1:0] mask_src = '0;
    logic            mask_src_none = 1'b0;
    logic [4:0]      mode = '0;
    logic            keep_outside = 1'b0;
    logic [XLEN-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    bmx_unit #(.XLEN(XLEN)) u_bmx_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .opnd          (opnd),
        .mask_src      (mask_src),
        .mask_src_none (mask_src_none),
        .mode          (mode),
        .keep_outside  (keep_outside),
        .result        (result)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: result=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [XLEN-1:0] a, input logic [XLEN-1:0] m,
                         input logic mz, input logic [4:0] md, input logic keep);
        @(negedge clk);
        opnd          = a;
        mask_src      = m;
        mask_src_none = mz;
        mode          = md;
        keep_outside  = keep;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        opnd = 64'hB8;
        mask_src_none = 1'b1;
        mode = 5'b10100;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].a, VECS[i].m, VECS[i].mz, VECS[i].md, VECS[i].keep);
            check(string'(VECS[i].tag), result, VECS[i].exp);
        end

        // R1: one-cycle latency, result holds previous value before the edge
        apply(64'h57, '0, 1'b1, 5'b10110, 1'b0);
        @(negedge clk);
        opnd = 64'hB8;
        mode = 5'b11001;
        #1;
        check("R1 hold", result, 64'h50);
        @(posedge clk);
        #1;
        check("R1 update", result, 64'h0F);

        // R2: mask_src ignored when the none flag is set (all-ones window)
        apply(64'hFF00, 64'h0000_0000_0000_000F, 1'b1, 5'b10100, 1'b0);
        check("R2 ignore", result, 64'h0100);

        // R6: partial window clips bits of an all-ones merge
        apply(64'h0, 64'h0000_FFFF_0000_0000, 1'b0, 5'b00101, 1'b0);
        check("R6 clip", result, 64'h0000_FFFF_0000_0000);

        // R1: reset in mid-run clears the output
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 midrun", result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule